// File: doc/BRIEF.md
# Event-Driven Delta-Modulation FIR Filter

This block filters a signal that arrives as a stream of level-crossing events instead of multi-bit samples. Each clock cycle carries at most one event: a step up by one quantizer level, a step down by one level, or nothing. The events go through a single chain of equal delay sections. Every tap has its own saturating up/down counter, which rebuilds a copy of the quantized input delayed by that tap's position in the chain. Only the event stream is delayed, so the chain holds two bits per stage and not one word per stage.

Each tap counter is read as an offset from mid-range and multiplied by a signed coefficient. The products are added at full precision and the sum is registered onto the output. Software-free coefficient loading uses a simple address/data write port. A strobe marks the output cycle that follows any change in a tap counter. Reset puts every counter at mid-range and empties the delay chain. As a result, each counter reaches mid-range exactly when the events that belong to it arrive.

Top module: `dm_fir_filter`

## Requirements
- R1: While rst_ni is low and in the first cycle after its release, every tap counter holds mid-range 2^(CNT_W-1), the delay chain holds no events, all coefficients are zero, y_o is 0 and y_valid_o is 0.
- R2: evt_i is a 2-bit event code: 2'b01 raises tap 0's counter by one, 2'b10 lowers it by one, and 2'b00 or 2'b11 leaves it unchanged. The code is applied at the rising edge where it is sampled.
- R3: A counter at its maximum 2^CNT_W-1 ignores an up event, and a counter at 0 ignores a down event. Neither counter wraps.
- R4: Tap k (k = 0..TAPS_K) applies the event sampled k*TD_CYCLES rising edges earlier. Tap 0 has no delay, and a tap sees no event until that many edges have passed since reset.
- R5: One edge after the counters and coefficients hold a set of values, y_o equals the two's-complement sum over k of coef_k * (cnt_k - 2^(CNT_W-1)), in CNT_W+COEF_W+clog2(TAPS_K+1) bits and with no truncation.
- R6: y_valid_o is 1 in exactly those cycles that follow an edge at which at least one tap counter changed value. An event that saturation blocks does not count as a change.
- R7: A write with coef_we_i=1 loads signed coef_data_i into tap coef_addr_i at the next edge. A write to an address of TAPS_K+1 or above changes no coefficient.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | 2 | Event code: 01 up, 10 down, 00/11 none |
| coef_we_i | input | 1 | Coefficient write enable |
| coef_addr_i | input | ADDR_W (3) | Tap index of the write |
| coef_data_i | input | COEF_W (8) | Signed coefficient value |
| y_o | output | OUT_W (14) | Registered two's-complement filter sum |
| y_valid_o | output | 1 | High in the cycle after any counter changed |

## Verification
The assertions assume that evt_i and the write port hold known values across each rising edge, and that only evt_i drives the counters. They observe tap 0 directly, and all taps through the change/strobe relation. The bench changes inputs only on the falling edge. It uses all four event codes, including the illegal 11. It runs the counters into both rails, walks a single-tap coefficient along the chain to expose each delay, and writes out-of-range addresses while the output is otherwise steady.

// File: rtl/dmfir_pkg.sv
package dmfir_pkg;
  typedef enum logic [1:0] {
    EVT_NONE = 2'b00,
    EVT_UP   = 2'b01,
    EVT_DN   = 2'b10,
    EVT_BOTH = 2'b11
  } evt_e;

  function automatic logic [1:0] evt_clean(input logic [1:0] e);
    return (e == EVT_BOTH) ? EVT_NONE : e;
  endfunction
endpackage

// File: rtl/dmfir_evt_delay.sv
module dmfir_evt_delay
  import dmfir_pkg::*;
#(
  parameter int NUM_SECT  = 3,
  parameter int TD_CYCLES = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [1:0]            evt_i,
  output logic [NUM_SECT*2-1:0] tap_evt_o
);
  localparam int LEN = NUM_SECT * TD_CYCLES;

  logic [1:0] line_q [LEN];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < LEN; i++) line_q[i] <= EVT_NONE;
    end else begin
      line_q[0] <= evt_clean(evt_i);
      for (int i = 1; i < LEN; i++) line_q[i] <= line_q[i-1];
    end
  end

  // section s output carries events (s+1)*TD_CYCLES edges old at the next edge
  for (genvar s = 0; s < NUM_SECT; s++) begin : g_tap
    assign tap_evt_o[s*2 +: 2] = line_q[(s+1)*TD_CYCLES-1];
  end
endmodule

// File: rtl/dmfir_tap_counter.sv
module dmfir_tap_counter
  import dmfir_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       evt_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             chg_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_MID = CNT_W'(1) << (CNT_W-1);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    unique case (evt_e'(evt_i))
      EVT_UP:  if (cnt_q != CNT_MAX) cnt_d = cnt_q + CNT_W'(1);
      EVT_DN:  if (cnt_q != '0)      cnt_d = cnt_q - CNT_W'(1);
      default: cnt_d = cnt_q;
    endcase
  end

  assign chg_o = (cnt_d != cnt_q);
  assign cnt_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= CNT_MID;
    else         cnt_q <= cnt_d;
  end
endmodule

// File: rtl/dmfir_coef_bank.sv
module dmfir_coef_bank #(
  parameter int NUM_TAPS = 4,
  parameter int COEF_W   = 8,
  parameter int ADDR_W   = 3
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       we_i,
  input  logic [ADDR_W-1:0]          addr_i,
  input  logic [COEF_W-1:0]          data_i,
  output logic [NUM_TAPS*COEF_W-1:0] coef_flat_o
);
  for (genvar k = 0; k < NUM_TAPS; k++) begin : g_coef
    logic [COEF_W-1:0] coef_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                coef_q <= '0;
      else if (we_i && addr_i == ADDR_W'(k))      coef_q <= data_i;
    end
    assign coef_flat_o[k*COEF_W +: COEF_W] = coef_q;
  end
endmodule

// File: rtl/dmfir_mac.sv
module dmfir_mac #(
  parameter int NUM_TAPS = 4,
  parameter int CNT_W    = 4,
  parameter int COEF_W   = 8,
  parameter int OUT_W    = 14
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [NUM_TAPS*CNT_W-1:0]  cnt_flat_i,
  input  logic [NUM_TAPS*COEF_W-1:0] coef_flat_i,
  input  logic                       chg_i,
  output logic [OUT_W-1:0]           y_o,
  output logic                       valid_o
);
  localparam logic signed [CNT_W:0] MID_X = (CNT_W+1)'(2 ** (CNT_W-1));

  logic signed [OUT_W-1:0] prod [NUM_TAPS];
  logic signed [OUT_W-1:0] acc;
  logic [OUT_W-1:0]        y_q;
  logic                    chg_q, valid_q;

  for (genvar k = 0; k < NUM_TAPS; k++) begin : g_prod
    logic signed [CNT_W:0]    off;
    logic signed [COEF_W-1:0] coef;
    assign off     = $signed({1'b0, cnt_flat_i[k*CNT_W +: CNT_W]}) - MID_X;
    assign coef    = $signed(coef_flat_i[k*COEF_W +: COEF_W]);
    assign prod[k] = OUT_W'(off) * OUT_W'(coef);
  end

  always_comb begin
    acc = '0;
    for (int k = 0; k < NUM_TAPS; k++) acc = acc + prod[k];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      y_q     <= '0;
      chg_q   <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      y_q     <= acc;
      chg_q   <= chg_i;
      valid_q <= chg_q;
    end
  end

  assign y_o     = y_q;
  assign valid_o = valid_q;
endmodule

// File: rtl/dm_fir_filter.sv
module dm_fir_filter #(
  parameter int  CNT_W     = 4,
  parameter int  COEF_W    = 8,
  parameter int  TAPS_K    = 3,
  parameter int  TD_CYCLES = 2,
  localparam int NUM_TAPS  = TAPS_K + 1,
  localparam int ADDR_W    = $clog2(NUM_TAPS) + 1,
  localparam int OUT_W     = CNT_W + COEF_W + $clog2(NUM_TAPS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        evt_i,
  input  logic              coef_we_i,
  input  logic [ADDR_W-1:0] coef_addr_i,
  input  logic [COEF_W-1:0] coef_data_i,
  output logic [OUT_W-1:0]  y_o,
  output logic              y_valid_o
);
  logic [TAPS_K*2-1:0]          tap_evt;
  logic [NUM_TAPS*CNT_W-1:0]    cnt_flat;
  logic [NUM_TAPS*COEF_W-1:0]   coef_flat;
  logic [NUM_TAPS-1:0]          chg;

  dmfir_evt_delay #(.NUM_SECT(TAPS_K), .TD_CYCLES(TD_CYCLES)) u_delay (
    .clk_i(clk_i), .rst_ni(rst_ni), .evt_i(evt_i), .tap_evt_o(tap_evt)
  );

  for (genvar k = 0; k < NUM_TAPS; k++) begin : g_tap
    logic [1:0] tap_in;
    if (k == 0) begin : g_head
      assign tap_in = evt_i;
    end else begin : g_body
      assign tap_in = tap_evt[(k-1)*2 +: 2];
    end
    dmfir_tap_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk_i(clk_i), .rst_ni(rst_ni), .evt_i(tap_in),
      .cnt_o(cnt_flat[k*CNT_W +: CNT_W]), .chg_o(chg[k])
    );
  end

  dmfir_coef_bank #(.NUM_TAPS(NUM_TAPS), .COEF_W(COEF_W), .ADDR_W(ADDR_W)) u_coef (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(coef_we_i), .addr_i(coef_addr_i),
    .data_i(coef_data_i), .coef_flat_o(coef_flat)
  );

  dmfir_mac #(.NUM_TAPS(NUM_TAPS), .CNT_W(CNT_W), .COEF_W(COEF_W), .OUT_W(OUT_W)) u_mac (
    .clk_i(clk_i), .rst_ni(rst_ni), .cnt_flat_i(cnt_flat), .coef_flat_i(coef_flat),
    .chg_i(|chg), .y_o(y_o), .valid_o(y_valid_o)
  );
endmodule

// File: rtl/dm_fir_filter_chk.sv
module dm_fir_filter_chk #(
  parameter int CNT_W    = 4,
  parameter int NUM_TAPS = 4
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic [1:0]                evt_i,
  input logic [NUM_TAPS*CNT_W-1:0] cnt_flat_i,
  input logic                      valid_i
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt0;
  assign cnt0 = cnt_flat_i[CNT_W-1:0];

  AST_UP_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i == 2'b01 && cnt0 != CNT_MAX) |=> cnt0 == $past(cnt0) + CNT_W'(1)); // R2
  AST_DN_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i == 2'b10 && cnt0 != '0) |=> cnt0 == $past(cnt0) - CNT_W'(1)); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i == 2'b00 || evt_i == 2'b11) |=> $stable(cnt0)); // R2
  AST_SAT_HI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i == 2'b01 && cnt0 == CNT_MAX) |=> cnt0 == CNT_MAX); // R3
  AST_SAT_LO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i == 2'b10 && cnt0 == '0) |=> cnt0 == '0); // R3
  AST_VALID_ON_CHG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_flat_i != $past(cnt_flat_i)) |=> valid_i); // R6
  AST_VALID_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_flat_i == $past(cnt_flat_i)) |=> !valid_i); // R6
endmodule

bind dm_fir_filter dm_fir_filter_chk #(.CNT_W(CNT_W), .NUM_TAPS(NUM_TAPS)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .evt_i(evt_i), .cnt_flat_i(cnt_flat), .valid_i(y_valid_o)
);

// File: tb/dm_fir_filter_tb.sv
module dm_fir_filter_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 4;
  localparam int COEF_W     = 8;
  localparam int TAPS_K     = 3;
  localparam int TD_CYCLES  = 2;
  localparam int NUM_TAPS   = TAPS_K + 1;
  localparam int ADDR_W     = $clog2(NUM_TAPS) + 1;
  localparam int OUT_W      = CNT_W + COEF_W + $clog2(NUM_TAPS);
  localparam int MID        = 2 ** (CNT_W-1);
  localparam int CMAX       = 2 ** CNT_W - 1;
  localparam int HIST       = 8192;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic [1:0]        evt_i = 2'b00;
  logic              coef_we_i = 1'b0;
  logic [ADDR_W-1:0] coef_addr_i = '0;
  logic [COEF_W-1:0] coef_data_i = '0;
  logic [OUT_W-1:0]  y_o;
  logic              y_valid_o;

  dm_fir_filter #(.CNT_W(CNT_W), .COEF_W(COEF_W), .TAPS_K(TAPS_K), .TD_CYCLES(TD_CYCLES)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .evt_i(evt_i), .coef_we_i(coef_we_i),
    .coef_addr_i(coef_addr_i), .coef_data_i(coef_data_i), .y_o(y_o), .y_valid_o(y_valid_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  // behavioural reference
  int         cnt_m  [NUM_TAPS];
  int         coef_m [NUM_TAPS];
  logic [1:0] ev_hist [HIST];
  int         n_edge;
  int         y_m;
  bit         v_m, chg_m;
  int unsigned seed = 32'h1234_5678;

  task automatic model_reset();
    for (int k = 0; k < NUM_TAPS; k++) begin cnt_m[k] = MID; coef_m[k] = 0; end
    n_edge = 0; y_m = 0; v_m = 0; chg_m = 0;
  endtask

  task automatic model_edge();
    int ysum; bit vnext; logic [1:0] e; int idx;
    ysum = 0;
    for (int k = 0; k < NUM_TAPS; k++) ysum += coef_m[k] * (cnt_m[k] - MID);
    vnext = chg_m;
    chg_m = 0;
    for (int k = 0; k < NUM_TAPS; k++) begin
      idx = n_edge - k*TD_CYCLES;
      e = (idx >= 0) ? ev_hist[idx % HIST] : 2'b00;
      if (k == 0) e = evt_i;
      if (e == 2'b01 && cnt_m[k] < CMAX) begin cnt_m[k]++; chg_m = 1; end
      else if (e == 2'b10 && cnt_m[k] > 0) begin cnt_m[k]--; chg_m = 1; end
    end
    ev_hist[n_edge % HIST] = evt_i;
    n_edge++;
    if (coef_we_i && int'(coef_addr_i) < NUM_TAPS)
      coef_m[coef_addr_i] = int'($signed(coef_data_i));
    y_m = ysum;
    v_m = vnext;
  endtask

  task automatic check_int(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic tick(input string req);
    @(posedge clk_i);
    model_edge();
    @(negedge clk_i);
    check_int(req, "y_o", int'($signed(y_o)), y_m);
    check_int("R6", "y_valid_o", int'(y_valid_o), int'(v_m));
  endtask

  task automatic wr_coef(input int addr, input int val, input string req);
    coef_we_i = 1'b1; coef_addr_i = ADDR_W'(addr); coef_data_i = COEF_W'(val);
    tick(req);
    coef_we_i = 1'b0;
  endtask

  task automatic evts(input logic [1:0] e, input int n, input string req);
    for (int i = 0; i < n; i++) begin evt_i = e; tick(req); end
    evt_i = 2'b00;
  endtask

  task automatic settle(input int n, input string req);
    evt_i = 2'b00;
    for (int i = 0; i < n; i++) tick(req);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    check_int("R1", "y_o in reset", int'($signed(y_o)), 0);
    check_int("R1", "y_valid_o in reset", int'(y_valid_o), 0);
    rst_ni = 1'b1;
    tick("R1");
    check_int("R1", "y_o after release", int'($signed(y_o)), 0);

    // R7: tap 0 gets weight 1, out-of-range writes do nothing
    wr_coef(0, 1, "R7");
    wr_coef(NUM_TAPS, 77, "R7");
    wr_coef(2**ADDR_W - 1, -50, "R7");
    settle(2, "R7");
    evts(2'b01, 1, "R7");
    settle(2, "R7");
    check_int("R7", "y after ignored writes", int'($signed(y_o)), 1);

    // R2: event codes
    evts(2'b01, 2, "R2");
    evts(2'b10, 1, "R2");
    evts(2'b11, 3, "R2");
    settle(2, "R2");
    check_int("R2", "tap0 offset", int'($signed(y_o)), 2);
    settle(3 * TD_CYCLES + 2, "R2");

    // R3: saturation at both rails
    evts(2'b01, 2 * CMAX, "R3");
    settle(2, "R3");
    check_int("R3", "tap0 at max", int'($signed(y_o)), CMAX - MID);
    evts(2'b10, 2 * CMAX, "R3");
    settle(2, "R3");
    check_int("R3", "tap0 at min", int'($signed(y_o)), -MID);
    evts(2'b01, MID, "R3");
    settle(3 * TD_CYCLES + 4, "R3");

    // R4: single-tap weight walks along the chain
    for (int t = 1; t < NUM_TAPS; t++) begin
      for (int k = 0; k < NUM_TAPS; k++) wr_coef(k, (k == t) ? 1 : 0, "R4");
      settle(3 * TD_CYCLES + 2, "R4");
      evts(2'b01, 1, "R4");
      for (int d = 0; d < t * TD_CYCLES + 2; d++) tick("R4");
      check_int("R4", "delayed tap step", int'($signed(y_o)), 1);
      evts(2'b10, 1, "R4");
      settle(3 * TD_CYCLES + 3, "R4");
    end

    // R5: mixed signed weights, pseudo-random events
    wr_coef(0, 3, "R5");
    wr_coef(1, -128, "R5");
    wr_coef(2, 127, "R5");
    wr_coef(3, -7, "R5");
    for (int i = 0; i < 600; i++) begin
      seed = seed * 32'd1103515245 + 32'd12345;
      evt_i = seed[17:16];
      if (i % 97 == 50) begin
        coef_we_i = 1'b1; coef_addr_i = seed[26:24]; coef_data_i = seed[31:24];
      end
      tick("R5");
      coef_we_i = 1'b0;
    end
    evts(2'b01, 40, "R5");
    settle(3 * TD_CYCLES + 3, "R5");
    evts(2'b10, 40, "R5");
    settle(3 * TD_CYCLES + 3, "R5");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule